// File: doc/BRIEF.md
# Configurable interrupt trigger detector

This block turns six raw interrupt inputs into qualified request lines. Four of the inputs come from external pins and two come from on-chip programmable logic. All of them arrive already synchronized to the block clock. Each source has its own 2-bit trigger selection:

- active-high level
- active-low level
- rising edge
- falling edge

In the two level modes the request tracks the input with no storage. In the two edge modes a detected transition sets a pending flag. The flag stays set until software clears it by writing a 1 to that source's bit in a clear register.

A per-source enable bit gates every request before it reaches the 6-bit request output. Software programs the trigger selection, the enables and the clears through one register write port. Arbitration between requests and vectoring are handled downstream. The asynchronous active-low reset is released synchronously inside the block.

Top module: `irq_trig_cond`

## Requirements
- R1: After reset every source is in mode 00, all enables are 0, no edge is pending and `req_o` is 0, whatever the inputs are. The previous-sample registers reset to 0.
- R2: A write with `wr_en`=1 selects its target by `wr_addr`. Address 00 loads the trigger fields from `wr_data[11:0]`. Address 01 loads the enables from `wr_data[5:0]`. Address 10 is the write-one-to-clear register at `wr_data[5:0]`. Each write takes effect at the clock edge where it is sampled.
- R3: Source i uses trigger field `wr_data[2i+1:2i]` and request bit `req_o[i]`. The sources are ordered as follows: 0 is `ext_irq_i[0]`, 1 is `ext_irq_i[1]`, 2 is `pl_irq_i[0]`, 3 is `ext_irq_i[2]`, 4 is `ext_irq_i[3]` and 5 is `pl_irq_i[1]`.
- R4: In mode 00 an enabled request equals the input in the same cycle.
- R5: In mode 01 an enabled request equals the inverted input in the same cycle.
- R6: In mode 10, a clock edge that samples the input at 1 after a previous sample of 0 sets the pending flag. The request is high from that edge on.
- R7: In mode 11, a clock edge that samples the input at 0 after a previous sample of 1 sets the pending flag. The request is high from that edge on.
- R8: A pending flag stays set until a clear write with a 1 in its bit. That write drops the flag at its clock edge. Clear bits written as 0 have no effect.
- R9: If a new edge is sampled at the same clock edge as a clear of that source, the flag stays set.
- R10: A configuration write that changes a source's field clears that source's pending flag. Rewriting the same field value leaves the flag unchanged.
- R11: In level modes, clear writes have no effect on the request.
- R12: With its enable at 0 a source's request is 0. Edges are still latched while the enable is 0, and a latched edge shows once the enable is set.
- R13: Writes to address 11 change nothing. Configuration data bits 31 to 12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 00 trigger fields, 01 enables, 10 clear, 11 unused |
| wr_data | input | 32 | Write data |
| ext_irq_i | input | 4 | Synchronized external interrupt inputs |
| pl_irq_i | input | 2 | Synchronized programmable-logic interrupt inputs |
| req_o | output | 6 | Qualified interrupt requests, bit i for source i |

## Verification
Level-mode requests depend combinationally on the input and on the registered enable, so they are due in the same cycle as the input change. Edge-mode requests are due from the first clock edge that samples the qualifying transition. Register writes act at the clock edge that samples them.

The bench therefore drives inputs and writes just after a falling clock edge and lets the rising edge capture them. It samples `req_o` 2 ns after that rising edge, against a cycle model in the bench that advances once per edge.

Sweeps cover every input combination in both level modes, long pseudo-random input streams in both edge modes and in mixed per-source modes, and directed sequences for clear, edge-with-clear, mode change and enable gating.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  localparam int unsigned MODE_W = 2;

  // Per-source trigger selection code
  typedef enum logic [MODE_W-1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_LVL_LO = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_FALL   = 2'b11
  } trig_mode_e;

  // Register write target
  typedef enum logic [1:0] {
    WSEL_CFG  = 2'b00,
    WSEL_EN   = 2'b01,
    WSEL_CLR  = 2'b10,
    WSEL_NONE = 2'b11
  } wr_sel_e;

endpackage

// File: rtl/irq_trig_rst_sync.sv
module irq_trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/irq_trig_regs.sv
module irq_trig_regs
  import irq_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_SRC*MODE_W-1:0] cfg_o,
  output logic [NUM_SRC-1:0]        en_o,
  output logic [NUM_SRC-1:0]        clr_o,
  output logic [NUM_SRC-1:0]        mode_chg_o
);

  localparam int unsigned CFG_W = NUM_SRC * MODE_W;

  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               cfg_wr, en_wr, clr_wr;
  logic               unused_upper;

  assign unused_upper = ^wr_data[DATA_W-1:CFG_W];

  // Decode of the write target
  always_comb begin
    cfg_wr = wr_en && (wr_sel_e'(wr_addr) == WSEL_CFG);
    en_wr  = wr_en && (wr_sel_e'(wr_addr) == WSEL_EN);
    clr_wr = wr_en && (wr_sel_e'(wr_addr) == WSEL_CLR);
    cfg_d  = wr_data[CFG_W-1:0];
    en_d   = wr_data[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_wr) begin
      en_q <= en_d;
    end
  end

  // Per-source strobes: a field changed by this write, and a clear pulse
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb begin
      mode_chg_o[i] = cfg_wr && (cfg_d[i*MODE_W +: MODE_W] != cfg_q[i*MODE_W +: MODE_W]);
      clr_o[i]      = clr_wr && wr_data[i];
    end
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;

  AST_EN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(wr_data[NUM_SRC-1:0]))); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q)); // R13

endmodule

// File: rtl/irq_trig_lane.sv
module irq_trig_lane
  import irq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       en,
  input  logic       clr,
  input  logic       mode_chg,
  input  logic       src_in,
  output logic       req
);

  logic prev_q;
  logic pend_q, pend_d, pend_upd;
  logic hit;
  logic raw_req;

  // Edge qualification against the previous sample
  always_comb begin
    unique case (mode)
      TRIG_RISE: hit = src_in & ~prev_q;
      TRIG_FALL: hit = ~src_in & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  // Pending flag next state: mode change > new edge > clear
  always_comb begin
    pend_upd = mode_chg | hit | clr;
    if (mode_chg) begin
      pend_d = 1'b0;
    end else if (hit) begin
      pend_d = 1'b1;
    end else begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= src_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_upd) begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_LVL_HI: raw_req = src_in;
      TRIG_LVL_LO: raw_req = ~src_in;
      default:     raw_req = pend_q;
    endcase
    req = en & raw_req;
  end

  AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_RISE && src_in && !prev_q && !mode_chg) |=> pend_q); // R6

  AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_FALL && !src_in && prev_q && !mode_chg) |=> pend_q); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr && !mode_chg) |=> pend_q); // R8

  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !mode_chg && mode == TRIG_RISE && src_in && !prev_q) |=> pend_q); // R9

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !pend_q); // R10

  AST_LEVEL_NOPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LVL_HI || mode == TRIG_LVL_LO) |-> !pend_q); // R11

endmodule

// File: rtl/irq_trig_cond.sv
module irq_trig_cond
  import irq_trig_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [2*NUM_GROUPS-1:0] ext_irq_i,
  input  logic [NUM_GROUPS-1:0]   pl_irq_i,
  output logic [3*NUM_GROUPS-1:0] req_o
);

  localparam int unsigned NUM_SRC = 3 * NUM_GROUPS;
  localparam int unsigned CFG_W   = NUM_SRC * MODE_W;

  logic               rst_n_sync;
  logic [CFG_W-1:0]   cfg_w;
  logic [NUM_SRC-1:0] en_w, clr_w, chg_w, src_w;

  irq_trig_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_trig_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cfg_o      (cfg_w),
    .en_o       (en_w),
    .clr_o      (clr_w),
    .mode_chg_o (chg_w)
  );

  // Source order per group: two external pins, then one programmable-logic input
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    if ((i % 3) == 2) begin : g_pl
      assign src_w[i] = pl_irq_i[i / 3];
    end else begin : g_ext
      assign src_w[i] = ext_irq_i[(i / 3) * 2 + (i % 3)];
    end

    irq_trig_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .mode     (trig_mode_e'(cfg_w[i*MODE_W +: MODE_W])),
      .en       (en_w[i]),
      .clr      (clr_w[i]),
      .mode_chg (chg_w[i]),
      .src_in   (src_w[i]),
      .req      (req_o[i])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_sync |-> (req_o == '0)); // R1

endmodule

// File: tb/irq_trig_cond_tb_top.sv
module irq_trig_cond_tb_top;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  ext_irq;
  logic [1:0]  pl_irq;
  logic [5:0]  req;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench model state
  logic [11:0] m_cfg;
  logic [5:0]  m_en, m_pend, m_prev;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  irq_trig_cond dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ext_irq_i (ext_irq),
    .pl_irq_i  (pl_irq),
    .req_o     (req)
  );

  task automatic drive_in(input logic [5:0] v);
    ext_irq = {v[4], v[3], v[1], v[0]};
    pl_irq  = {v[5], v[2]};
  endtask

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: req_o actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] model_req(input logic [5:0] in6);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) begin
      case (m_cfg[2*i +: 2])
        2'b00:   r[i] = m_en[i] & in6[i];
        2'b01:   r[i] = m_en[i] & ~in6[i];
        default: r[i] = m_en[i] & m_pend[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // One clock: drive after negedge, model update at posedge, sample 2 ns later
  task automatic tick(input logic [5:0] in6, input logic we, input logic [1:0] wa,
                      input logic [31:0] wd, input string tag);
    logic [5:0]  np;
    logic [11:0] ncfg;
    @(negedge clk);
    drive_in(in6);
    wr_en   = we;
    wr_addr = wa;
    wr_data = wd;
    @(posedge clk);
    ncfg = (we && wa == 2'b00) ? wd[11:0] : m_cfg;
    for (int i = 0; i < 6; i++) begin
      logic [1:0] md;
      logic       e, c, chg;
      md  = m_cfg[2*i +: 2];
      chg = (ncfg[2*i +: 2] != md);
      e   = (md == 2'b10) ? (in6[i] & ~m_prev[i]) :
            (md == 2'b11) ? (~in6[i] & m_prev[i]) : 1'b0;
      c   = we && (wa == 2'b10) && wd[i];
      if (chg)    np[i] = 1'b0;
      else if (e) np[i] = 1'b1;
      else if (c) np[i] = 1'b0;
      else        np[i] = m_pend[i];
    end
    m_pend = np;
    m_cfg  = ncfg;
    if (we && wa == 2'b01) m_en = wd[5:0];
    m_prev = in6;
    #2ns;
    check(tag, req, model_req(in6));
  endtask

  task automatic idle(input logic [5:0] in6, input string tag);
    tick(in6, 1'b0, 2'b00, 32'h0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'b00; wr_data = '0;
    drive_in(6'h3F);
    m_cfg = '0; m_en = '0; m_pend = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    #2ns;
    check("R1 in reset", req, 6'h00);
    @(negedge clk);
    drive_in(6'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2ns;
    check("R1 after reset", req, 6'h00);
    idle(6'h3F, "R1 enables off");

    // Enable all, mode 00 level sweep
    tick(6'h00, 1'b1, 2'b01, 32'h3F, "R2 enable write");
    for (int v = 0; v < 64; v++) idle(v[5:0], "R4 level high sweep");
    for (int i = 0; i < 6; i++) idle(6'(1 << i), "R3 source mapping");

    // Active-low level sweep
    tick(6'h00, 1'b1, 2'b00, 32'h555, "R2 cfg write");
    for (int v = 0; v < 64; v++) idle(v[5:0], "R5 level low sweep");
    tick(6'h2A, 1'b1, 2'b10, 32'h3F, "R11 clear in level mode");
    idle(6'h2A, "R11 after clear");

    // Rising edge stream
    tick(6'h00, 1'b1, 2'b00, 32'hAAA, "R10 switch to rise");
    for (int k = 0; k < 120; k++) begin
      lfsr = lfsr_next(lfsr);
      idle(lfsr[5:0], "R6 rising stream");
    end
    tick(6'h00, 1'b1, 2'b10, 32'h3F, "R8 clear all");
    idle(6'h00, "R8 cleared");

    // Falling edge stream
    tick(6'h3F, 1'b1, 2'b00, 32'hFFF, "R10 switch to fall");
    for (int k = 0; k < 120; k++) begin
      lfsr = lfsr_next(lfsr);
      idle(lfsr[5:0], "R7 falling stream");
    end

    // Partial clear and zero clear bits
    tick(6'h00, 1'b1, 2'b00, 32'hAAA, "R10 back to rise");
    idle(6'h3F, "R6 all rise");
    tick(6'h3F, 1'b1, 2'b10, 32'h00, "R8 zero clear bits");
    tick(6'h3F, 1'b1, 2'b10, 32'h15, "R8 partial clear");
    idle(6'h00, "R8 hold others");

    // Edge together with clear
    tick(6'h00, 1'b1, 2'b10, 32'h3F, "R8 clear rest");
    tick(6'h3F, 1'b1, 2'b10, 32'h3F, "R9 edge with clear");
    idle(6'h3F, "R9 still pending");

    // Same-mode rewrite keeps, different mode flushes
    tick(6'h3F, 1'b1, 2'b00, 32'hAAA, "R10 same mode keeps");
    tick(6'h3F, 1'b1, 2'b00, 32'hFFF, "R10 change flushes");
    idle(6'h3F, "R10 after flush");

    // Enable gating while edges latch
    tick(6'h00, 1'b1, 2'b00, 32'hAAA, "R12 rise mode");
    tick(6'h00, 1'b1, 2'b01, 32'h00, "R12 disable");
    idle(6'h3F, "R12 disabled edge");
    idle(6'h3F, "R12 disabled hold");
    tick(6'h3F, 1'b1, 2'b01, 32'h3F, "R12 re-enable shows latch");

    // Unused address and reserved configuration bits
    tick(6'h3F, 1'b1, 2'b11, 32'hFFFF_FFFF, "R13 unused address");
    tick(6'h3F, 1'b1, 2'b00, 32'hFFFF_FAAA, "R13 reserved bits");
    tick(6'h00, 1'b1, 2'b00, 32'hFFFF_F000, "R13 reserved to level");
    idle(6'h15, "R13 level after reserved");

    // Mixed per-source modes with random inputs, clears and enables
    for (int c = 0; c < 64; c++) begin
      lfsr = lfsr_next(lfsr);
      tick(lfsr[5:0], 1'b1, 2'b00, {20'h0, lfsr[11:0] ^ 12'(c * 12'h2C5)}, "R3 mixed cfg");
      for (int k = 0; k < 12; k++) begin
        lfsr = lfsr_next(lfsr);
        case (lfsr[9:8])
          2'b00:   tick(lfsr[5:0], 1'b1, 2'b10, {26'h0, lfsr[15:10]}, "R8 mixed clear");
          2'b01:   tick(lfsr[5:0], 1'b1, 2'b01, {26'h0, lfsr[15:10] | 6'h30}, "R12 mixed enable");
          default: idle(lfsr[5:0], "R3 mixed stream");
        endcase
      end
    end

    finish_run();
  end

endmodule